// File: doc/BRIEF.md
# Program/Erase Status Read Generator

This block sits between a flash array's read path and the external data bus. It times an embedded program or erase operation with an internal cycle counter. While that operation runs, it replaces two bits of every read with status codes that software can poll. Bit 7 carries a completion flag. During a program it is the inverse of bit 7 of the word being written, and during an erase it is held at 0. Bit 6 flips on every completed read access, so two reads in a row differ for as long as the operation is in progress. All other bits pass the array value through.

When the timed period expires, the busy flag drops and reads return the array word unchanged on all bits. A start request that arrives while busy is dropped. The busy output lets the command decoder apply the same rule. A synchronous reset at any point ends the operation at once.

The array contents, the addressing and the command decoding are outside this block. Status codes apply to any read made while busy.

Top module: `pe_status_reader`

## Requirements
- R1: While reset is asserted, and on the cycle after it, `busy` is 0 and `rd_data` equals `array_rdata` on all bits.
- R2: A `start_prog` accepted while idle raises `busy` on the next cycle. `busy` then stays high for exactly `PROG_CYCLES` cycles.
- R3: A `start_erase` accepted while idle raises `busy` on the next cycle. `busy` then stays high for exactly `ERASE_CYCLES` cycles.
- R4: While a program is busy, `rd_data[7]` is the inverse of bit 7 of `load_data` as sampled on the accepting cycle.
- R5: While an erase is busy, `rd_data[7]` is 0.
- R6: While busy, `rd_data[6]` is 0 until the first trailing edge of `rd_strobe` after acceptance. It then inverts after each trailing edge (`rd_strobe` sampled 1 on one clock and 0 on the next). The new value appears on the cycle after the edge that samples the 0.
- R7: While busy, every `rd_data` bit other than 7 and 6 equals the same bit of `array_rdata`.
- R8: While not busy, `rd_data` equals `array_rdata` on all bits, including bits 7 and 6.
- R9: A `start_prog` or `start_erase` that arrives while busy is ignored. It neither lengthens the busy period nor changes the bit 7 code.
- R10: If `start_prog` and `start_erase` arrive together while idle, the erase is started.
- R11: Reset asserted during a busy period clears `busy` on the next cycle. Reads then return true array data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; aborts any running operation |
| start_prog | input | 1 | Request to start a program operation |
| start_erase | input | 1 | Request to start an erase operation |
| load_data | input | DW | Word being programmed, sampled with `start_prog` |
| rd_strobe | input | 1 | Read access strobe; its trailing edge advances the toggle bit |
| array_rdata | input | DW | Word read from the array |
| rd_data | output | DW | Value returned on the read bus |
| busy | output | 1 | High while an operation is in progress; commands are refused |

## Verification
The hardest situations to reach are the ones where two events meet on the same edge. One is a start request on the final busy cycle: it must still be refused, because busy has not yet fallen. Another is a read strobe that falls on the accepting edge, where the clear of the toggle bit must win over the flip. A third is a reset in the middle of an operation.

The stimulus reaches these states with directed sequences: a second start while already busy, simultaneous program and erase requests, and a reset mid-program and mid-erase. It then runs long random segments. In these, strobes, start requests and occasional resets land on arbitrary cycles relative to the counter, which sweeps these coincidences past every edge.

// File: rtl/pe_status_pkg.sv
// Shared types and helpers for the program/erase status read generator.
// Assumes: nothing beyond IEEE 1800-2017 constant functions.
package pe_status_pkg;

    // Kind of embedded operation in progress.
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2
    } pe_op_e;

    // Larger of two cycle counts, used to size the shared counter.
    function automatic int unsigned max_cycles(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pe_op_timer.sv
// Operation timer: accepts a program or erase start while idle and holds busy
// for a parameterised number of cycles. It also latches the bit 7 status code
// (inverted loaded bit for program, 0 for erase).
// Assumes: start requests are single-cycle or level; any request seen while
// busy is dropped. Erase wins over program on the same cycle.
module pe_op_timer
    import pe_status_pkg::*;
#(
    parameter int unsigned PROG_CYCLES  = 32,
    parameter int unsigned ERASE_CYCLES = 96
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start_prog,
    input  logic   start_erase,
    input  logic   prog_bit,
    output logic   busy,
    output logic   accept,
    output logic   poll_val,
    output pe_op_e op
);
    localparam int unsigned MAXC = max_cycles(PROG_CYCLES, ERASE_CYCLES);
    localparam int unsigned CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] PROG_LOAD  = CW'(PROG_CYCLES - 1);
    localparam logic [CW-1:0] ERASE_LOAD = CW'(ERASE_CYCLES - 1);

    logic          busy_q;
    logic          poll_q;
    logic [CW-1:0] cnt_q;
    pe_op_e        op_q;

    // A request is taken only when no operation is running.
    assign accept = !busy_q && (start_prog || start_erase);

    // Load, count down and retire the running operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            poll_q <= 1'b0;
            cnt_q  <= '0;
            op_q   <= OP_NONE;
        end else if (accept) begin
            busy_q <= 1'b1;
            if (start_erase) begin
                op_q   <= OP_ERASE;
                cnt_q  <= ERASE_LOAD;
                poll_q <= 1'b0;
            end else begin
                op_q   <= OP_PROG;
                cnt_q  <= PROG_LOAD;
                poll_q <= ~prog_bit;
            end
        end else if (busy_q) begin
            if (cnt_q == '0) begin
                busy_q <= 1'b0;
                op_q   <= OP_NONE;
            end else begin
                cnt_q <= cnt_q - CW'(1);
            end
        end
    end

    assign busy     = busy_q;
    assign poll_val = poll_q;
    assign op       = op_q;

    // Busy cannot fall while cycles remain.
    assert_busy_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && (cnt_q != '0) |=> busy_q);

    // A program start latches the inverted data bit.
    assert_prog_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !start_erase |=> (poll_q == ~$past(prog_bit)) && (op_q == OP_PROG));

    // Erase start latches a zero code and loads the erase length.
    assert_erase_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        accept && start_erase |=> !poll_q && (op_q == OP_ERASE) && (cnt_q == ERASE_LOAD));

    // Requests during a running operation change nothing.
    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && (cnt_q != '0) && (start_prog || start_erase)
        |=> $stable(poll_q) && $stable(op_q) && (cnt_q == $past(cnt_q) - CW'(1)));

    // Erase wins a tie with program.
    assert_erase_priority_R10: assert property (@(posedge clk) disable iff (!rst_n)
        accept && start_prog && start_erase |=> (op_q == OP_ERASE));

    // Reset ends any operation on the next cycle.
    assert_reset_abort_R11: assert property (@(posedge clk)
        !rst_n |=> !busy_q && (op_q == OP_NONE));

endmodule

// File: rtl/pe_toggle_gen.sv
// Toggle bit generator: flips a status bit on each trailing edge of the read
// strobe while an operation is busy, and starts from 0 on every accepted start.
// Assumes: rd_strobe is synchronous to clk; the trailing edge is seen as
// 1 on one clock and 0 on the next.
module pe_toggle_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_strobe,
    input  logic busy,
    input  logic clear,
    output logic tog
);
    logic strobe_q;
    logic tog_q;
    logic fall;

    // Trailing edge of the read strobe.
    assign fall = strobe_q && !rd_strobe;

    // Track the strobe and advance the toggle bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
            tog_q    <= 1'b0;
        end else begin
            strobe_q <= rd_strobe;
            if (clear) begin
                tog_q <= 1'b0;
            end else if (busy && fall) begin
                tog_q <= ~tog_q;
            end
        end
    end

    assign tog = tog_q;

    // Each read completed while busy inverts the bit.
    assert_toggle_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy && fall && !clear |=> tog_q != $past(tog_q));

    // Without a completed read the bit holds.
    assert_toggle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && fall) && !clear |=> $stable(tog_q));

    // A new operation starts the sequence at 0.
    assert_toggle_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !tog_q);

endmodule

// File: rtl/pe_read_mux.sv
// Read bus multiplexer: substitutes the polling and toggle status bits into
// the array word while busy; passes the array word unchanged otherwise.
// Assumes: POLL_BIT and TOGGLE_BIT are distinct and below DW.
module pe_read_mux #(
    parameter int unsigned DW         = 16,
    parameter int unsigned POLL_BIT   = 7,
    parameter int unsigned TOGGLE_BIT = 6
) (
    input  logic          busy,
    input  logic          poll_val,
    input  logic          tog,
    input  logic [DW-1:0] array_rdata,
    output logic [DW-1:0] rd_data
);
    // One selector per bit; the parameter picks which source each bit uses.
    for (genvar b = 0; b < DW; b++) begin : g_bit
        if (b == POLL_BIT) begin : g_poll
            assign rd_data[b] = busy ? poll_val : array_rdata[b];
        end else if (b == TOGGLE_BIT) begin : g_tog
            assign rd_data[b] = busy ? tog : array_rdata[b];
        end else begin : g_pass
            assign rd_data[b] = array_rdata[b];
        end
    end

endmodule

// File: rtl/pe_status_reader.sv
// Program/erase status read generator (top). Times an embedded program or
// erase and, while it runs, returns the polling code on bit 7 and a
// read-advanced toggle on bit 6, with true array data otherwise.
// Assumes: synchronous active-low reset; the command decoder honours busy.
module pe_status_reader
    import pe_status_pkg::*;
#(
    parameter int unsigned DW           = 16,
    parameter int unsigned PROG_CYCLES  = 32,
    parameter int unsigned ERASE_CYCLES = 96,
    parameter int unsigned POLL_BIT     = 7,
    parameter int unsigned TOGGLE_BIT   = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_prog,
    input  logic          start_erase,
    input  logic [DW-1:0] load_data,
    input  logic          rd_strobe,
    input  logic [DW-1:0] array_rdata,
    output logic [DW-1:0] rd_data,
    output logic          busy
);
    localparam logic [DW-1:0] ONE_HOT0  = {{(DW-1){1'b0}}, 1'b1};
    localparam logic [DW-1:0] PASS_MASK =
        ~((ONE_HOT0 << POLL_BIT) | (ONE_HOT0 << TOGGLE_BIT));

    logic   busy_w;
    logic   accept_w;
    logic   poll_w;
    logic   tog_w;
    pe_op_e op_w;
    logic   load_unused;

    // Only the polled bit of the loaded word matters here.
    assign load_unused = ^load_data;

    pe_op_timer #(
        .PROG_CYCLES (PROG_CYCLES),
        .ERASE_CYCLES(ERASE_CYCLES)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_prog (start_prog),
        .start_erase(start_erase),
        .prog_bit   (load_data[POLL_BIT]),
        .busy       (busy_w),
        .accept     (accept_w),
        .poll_val   (poll_w),
        .op         (op_w)
    );

    pe_toggle_gen u_toggle (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_strobe(rd_strobe),
        .busy     (busy_w),
        .clear    (accept_w),
        .tog      (tog_w)
    );

    pe_read_mux #(
        .DW        (DW),
        .POLL_BIT  (POLL_BIT),
        .TOGGLE_BIT(TOGGLE_BIT)
    ) u_mux (
        .busy       (busy_w),
        .poll_val   (poll_w),
        .tog        (tog_w),
        .array_rdata(array_rdata),
        .rd_data    (rd_data)
    );

    assign busy = busy_w;

    // Erase status reads 0 on the polling bit.
    assert_erase_poll_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy_w && (op_w == OP_ERASE) |-> !rd_data[POLL_BIT]);

    // Bits outside the status pair always follow the array.
    assert_pass_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & PASS_MASK) == (array_rdata & PASS_MASK));

    // Idle reads return the array word unchanged.
    assert_idle_true_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_w |-> rd_data == array_rdata);

    // Busy and the operation kind agree.
    assert_busy_kind_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_w == (op_w != OP_NONE));

endmodule

// File: tb/pe_status_reader_bench.sv
// Self-checking bench: directed corner cases plus seeded random segments,
// compared each cycle against a requirement-level model held in the bench.
module pe_status_reader_bench;
    localparam int unsigned DW = 16;
    localparam int unsigned PC = 24;
    localparam int unsigned EC = 60;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_prog = 1'b0;
    logic          start_erase = 1'b0;
    logic [DW-1:0] load_data = '0;
    logic          rd_strobe = 1'b0;
    logic [DW-1:0] array_rdata = '0;
    logic [DW-1:0] rd_data;
    logic          busy;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;
    string g_tag = "R1";

    // Model state (value after the coming clock edge once updated).
    bit m_busy = 0;
    int m_left = 0;
    int m_kind = 0;   // 0 none, 1 program, 2 erase
    bit m_poll = 0;
    bit m_tog = 0;
    bit m_sq = 0;

    always #2 clk = ~clk;

    pe_status_reader #(
        .DW(DW), .PROG_CYCLES(PC), .ERASE_CYCLES(EC),
        .POLL_BIT(7), .TOGGLE_BIT(6)
    ) u_pe_status_reader (
        .clk(clk), .rst_n(rst_n), .start_prog(start_prog),
        .start_erase(start_erase), .load_data(load_data),
        .rd_strobe(rd_strobe), .array_rdata(array_rdata),
        .rd_data(rd_data), .busy(busy)
    );

    // Expected read value from the requirements R4..R8.
    function automatic logic [DW-1:0] exp_rd(bit b, bit p, bit t, logic [DW-1:0] a);
        logic [DW-1:0] r = a;
        if (b) begin
            r[7] = p;
            r[6] = t;
        end
        return r;
    endfunction

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: drive at the falling edge, check, then advance the model.
    task automatic cycle(bit sp, bit se, logic [DW-1:0] d, bit strb, bit rst);
        logic [DW-1:0] e;
        bool_accept: begin end
        @(negedge clk);
        rst_n       = !rst;
        start_prog  = sp;
        start_erase = se;
        load_data   = d;
        rd_strobe   = strb;
        array_rdata = DW'($urandom);
        #1;
        check({g_tag, " busy"}, DW'(busy), DW'(m_busy));
        e = exp_rd(m_busy, m_poll, m_tog, array_rdata);
        if (m_busy) begin
            check(m_kind == 2 ? "R5 bit7" : "R4 bit7", DW'(rd_data[7]), DW'(e[7]));
            check("R6 bit6", DW'(rd_data[6]), DW'(e[6]));
            check("R7 pass bits", rd_data & 16'hFF3F, e & 16'hFF3F);
        end else begin
            check(g_tag == "R1" ? "R1 idle read" : "R8 idle read", rd_data, e);
        end
        if (rst) begin
            m_busy = 0; m_kind = 0; m_poll = 0; m_tog = 0; m_sq = 0; m_left = 0;
        end else begin
            if (!m_busy && (sp || se)) begin
                m_busy = 1;
                m_kind = se ? 2 : 1;
                m_left = se ? EC : PC;
                m_poll = se ? 1'b0 : ~d[7];
                m_tog  = 0;
            end else if (m_busy) begin
                if (m_sq && !strb) m_tog = ~m_tog;
                m_left--;
                if (m_left == 0) begin
                    m_busy = 0;
                    m_kind = 0;
                end
            end
            m_sq = strb;
        end
    endtask

    // Idle or busy cycles with read pulses every other cycle.
    task automatic reads(int n);
        for (int i = 0; i < n; i++) cycle(0, 0, '0, (i % 2) == 0, 0);
    endtask

    initial begin
        int seg;
        // R1: reset state
        g_tag = "R1";
        for (int i = 0; i < 4; i++) cycle(0, 0, '0, 0, 1);
        cycle(0, 0, '0, 0, 0);
        // R2/R4: program with bit7 set, then clear
        g_tag = "R2";
        cycle(1, 0, 16'h0080, 0, 0);
        reads(PC + 3);
        cycle(1, 0, 16'h1234, 0, 0);
        reads(PC + 3);
        // R3/R5: erase
        g_tag = "R3";
        cycle(0, 1, '0, 0, 0);
        reads(EC + 3);
        // R9: starts while busy ignored, including on the final busy cycle
        g_tag = "R9";
        cycle(1, 0, 16'h0000, 0, 0);
        reads(5);
        cycle(1, 0, 16'h0080, 1, 0);
        cycle(0, 1, '0, 0, 0);
        reads(PC - 8);
        cycle(1, 1, 16'h0080, 0, 0);
        reads(4);
        // R10: simultaneous requests pick erase
        g_tag = "R10";
        cycle(1, 1, 16'h0000, 0, 0);
        reads(EC + 2);
        // R11: reset mid-program and mid-erase
        g_tag = "R11";
        cycle(1, 0, 16'h00FF, 0, 0);
        reads(7);
        cycle(0, 0, '0, 0, 1);
        reads(4);
        cycle(0, 1, '0, 1, 0);
        reads(9);
        cycle(0, 0, '0, 1, 1);
        reads(4);
        // R6: toggle with strobe falling on the accepting edge
        g_tag = "R6";
        cycle(0, 0, '0, 1, 0);
        cycle(1, 0, 16'h0055, 0, 0);
        reads(PC + 2);
        // Random segments
        void'($urandom(32'h5EED_1234));
        g_tag = "R2";
        for (seg = 0; seg < 40; seg++) begin
            int len = 10 + ($urandom % 90);
            for (int i = 0; i < len; i++) begin
                int r = $urandom % 100;
                cycle(r < 4, (r >= 4) && (r < 6), DW'($urandom),
                      ($urandom % 3) == 0, r == 99);
            end
        end
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule